// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches the high nibble of an 8-bit general-purpose port and raises an interrupt when a monitored input no longer matches the value seen at the last software access. Pin levels pass through a two-stage synchronizer. A snapshot register holds the synchronized nibble and reloads on every port read or port write strobe. Each bit whose direction bit marks it as an input is compared with its snapshot bit. Any difference sets a sticky flag.

The flag cannot be cleared while a difference remains, because the set condition is evaluated again on every cycle. Software therefore ends the condition with a port access before it clears the flag. The flag drives a wake request, which a sleeping core uses to resume. A typical use is a keypad: software reads the port inside the handler and then clears the flag.

Top module: `port_change_detect`

## Requirements
- R1: Only port bits 7..4 are monitored. A change on bits 3..0 never sets the flag.
- R2: A monitored bit whose direction bit is 0 (output) is excluded from the comparison. If its direction bit later becomes 1 while its level differs from the snapshot, the flag sets on the next clock edge.
- R3: The comparison value is the synchronized nibble captured at the most recent port read or write. It is not the previous cycle's value, so a return to an older level also counts as a mismatch.
- R4: A mismatch on any monitored input sets the flag. A pin change driven before clock edge N appears on the flag after edge N+2, and not after edge N+1.
- R5: While a mismatch persists, a flag-clear strobe has no effect and the flag stays at 1.
- R6: Asserting the read or write strobe for one cycle reloads the snapshot. Once the mismatch has ended, a clear strobe drops the flag at the next edge.
- R7: If a clear strobe and a mismatch are both present at the same edge, the flag is set.
- R8: The wake request equals the flag in every cycle.
- R9: Synchronous active-high reset clears the flag and loads the snapshot from the synchronized pins. With static pins, the flag stays at 0 after reset.
- R10: The flag is sticky. If a pin returns to its snapshot level without an access, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Raw port pin levels |
| dir_i | input | 8 | Direction bits, 1 = input, 0 = output |
| port_rd_i | input | 1 | One-cycle strobe for a port read |
| port_wr_i | input | 1 | One-cycle strobe for a port write |
| flag_clr_i | input | 1 | One-cycle software clear of the flag |
| irq_flag_o | output | 1 | Sticky port change flag |
| wake_o | output | 1 | Wake request to a sleeping core |

## Verification
The assertions assume that the strobes and the direction bits are already synchronous to `clk_i` and change only between edges. They also assume that reset is held long enough for the synchronizer to fill with settled pin levels before the snapshot is trusted. The bench drives every input just after the falling edge and holds reset for six cycles with pins steady, so both assumptions hold. Random stimulus changes pins, direction and strobes at low rates, so the run covers long-lived mismatches, accesses and clears that coincide with new changes.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    localparam int PORT_W      = 8;
    localparam int MON_LSB     = 4;
    localparam int MON_W       = PORT_W - MON_LSB;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        FLAG_HOLD = 2'd0,
        FLAG_SET  = 2'd1,
        FLAG_CLR  = 2'd2
    } flag_act_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic clr;
    } host_evt_t;

    // Set outranks clear: a live mismatch re-asserts every cycle.
    function automatic flag_act_e pick_action(input logic mismatch, input logic clr);
        if (mismatch)
            return FLAG_SET;
        else if (clr)
            return FLAG_CLR;
        return FLAG_HOLD;
    endfunction

    function automatic logic apply_action(input flag_act_e act, input logic cur);
        case (act)
            FLAG_SET: return 1'b1;
            FLAG_CLR: return 1'b0;
            default:  return cur;
        endcase
    endfunction

    function automatic logic is_access(input host_evt_t ev);
        return ev.rd | ev.wr;
    endfunction

endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i) stage_q[s] <= d_i;
        end else begin : g_rest
            always_ff @(posedge clk_i) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcd_snapshot.sv
module pcd_snapshot #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         access_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] dir_i,
    output logic         mismatch_o
);

    logic [W-1:0] snap_q;
    logic [W-1:0] diff_bits;

    always_ff @(posedge clk_i) begin
        if (rst_i || access_i)
            snap_q <= live_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_cmp
        assign diff_bits[b] = dir_i[b] & (live_i[b] ^ snap_q[b]);
    end

    assign mismatch_o = |diff_bits;

    // R6: an access captures the live nibble seen at that edge
    assert_snap_reload_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        access_i |=> (snap_q == $past(live_i)));

    // R2: with every monitored bit set to output there is never a mismatch
    assert_outputs_excluded_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (dir_i == '0) |-> !mismatch_o);

endmodule

// File: rtl/pcd_flag.sv
module pcd_flag
    import pcd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic mismatch_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_act_e act;
    logic      flag_q;

    assign act = pick_action(mismatch_i, clr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            flag_q <= 1'b0;
        else
            flag_q <= apply_action(act, flag_q);
    end

    assign flag_o = flag_q;

    // R5, R7: a mismatch always leaves the flag set, clear or not
    assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        mismatch_i |=> flag_q);

    // R6: a clear without a mismatch drops the flag
    assert_clear_takes_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && !mismatch_i) |=> !flag_q);

    // R4: the flag only rises after a mismatch
    assert_rise_cause_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(flag_q) |-> $past(mismatch_i));

    // R10: without a clear the flag never falls
    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/port_change_detect.sv
module port_change_detect
    import pcd_pkg::*;
#(
    parameter int PW   = PORT_W,
    parameter int LSB  = MON_LSB,
    parameter int SYNC = SYNC_STAGES
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [PW-1:0] pin_i,
    input  logic [PW-1:0] dir_i,
    input  logic          port_rd_i,
    input  logic          port_wr_i,
    input  logic          flag_clr_i,
    output logic          irq_flag_o,
    output logic          wake_o
);

    localparam int MW = PW - LSB;

    host_evt_t     evt;
    logic [MW-1:0] pin_mon;
    logic [MW-1:0] dir_mon;
    logic [MW-1:0] live;
    logic          mismatch;
    logic          flag;
    logic          unused_low;

    assign evt        = '{rd: port_rd_i, wr: port_wr_i, clr: flag_clr_i};
    assign pin_mon    = pin_i[PW-1:LSB];
    assign dir_mon    = dir_i[PW-1:LSB];
    assign unused_low = ^{pin_i[LSB-1:0], dir_i[LSB-1:0]};

    pcd_sync #(.W(MW), .STAGES(SYNC)) u_sync (
        .clk_i (clk_i),
        .d_i   (pin_mon),
        .q_o   (live)
    );

    pcd_snapshot #(.W(MW)) u_snap (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .access_i   (is_access(evt)),
        .live_i     (live),
        .dir_i      (dir_mon),
        .mismatch_o (mismatch)
    );

    pcd_flag u_flag (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mismatch_i (mismatch),
        .clr_i      (evt.clr),
        .flag_o     (flag)
    );

    assign irq_flag_o = flag;
    assign wake_o     = flag;

    // R9: the cycle after reset the flag is low
    assert_reset_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !irq_flag_o);

endmodule

// File: tb/tb_port_change_detect.sv
`timescale 1ns/1ps
module tb_port_change_detect;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pin, dir;
    logic       rd, wr, clr;
    logic       flag, wake;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    port_change_detect dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .pin_i      (pin),
        .dir_i      (dir),
        .port_rd_i  (rd),
        .port_wr_i  (wr),
        .flag_clr_i (clr),
        .irq_flag_o (flag),
        .wake_o     (wake)
    );

    // Reference model built from the requirements
    logic [7:0] m_s1, m_s2;
    logic [3:0] m_snap;
    logic       m_flag;

    function automatic logic model_mismatch(input logic [7:0] live, input logic [3:0] snap,
                                            input logic [7:0] d);
        return |((live[7:4] ^ snap) & d[7:4]);
    endfunction

    always @(posedge clk) begin
        m_s1 <= pin;
        m_s2 <= m_s1;
        if (rst) begin
            m_snap <= m_s2[7:4];
            m_flag <= 1'b0;
        end else begin
            if (rd || wr) m_snap <= m_s2[7:4];
            if (model_mismatch(m_s2, m_snap, dir)) m_flag <= 1'b1;
            else if (clr)                          m_flag <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic access_then_clear(input bit use_wr, input string req);
        if (use_wr) wr = 1'b1; else rd = 1'b1;
        tick();
        rd = 1'b0; wr = 1'b0;
        tick();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        chk(req, flag, 1'b0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; pin = 8'hA5; dir = 8'hFF; rd = 0; wr = 0; clr = 0;
        tick(6);
        rst = 1'b0;
        tick();
        chk("R9", flag, 1'b0);
        chk("R8", wake, 1'b0);
        tick(4);
        chk("R9", flag, 1'b0);

        // R1: low nibble is ignored
        pin = pin ^ 8'h0F;
        tick(5);
        chk("R1", flag, 1'b0);

        // R2: output bits excluded, rejoin when turned to input
        dir = 8'h0F;
        pin = pin ^ 8'h80;
        tick(5);
        chk("R2", flag, 1'b0);
        dir = 8'hFF;
        tick();
        chk("R2", flag, 1'b1);
        access_then_clear(1'b0, "R6");

        // R4: latency of three edges
        pin = pin ^ 8'h20;
        tick(2);
        chk("R4", flag, 1'b0);
        tick();
        chk("R4", flag, 1'b1);
        chk("R8", wake, 1'b1);

        // R5: clear ignored while mismatch remains
        clr = 1'b1; tick(); clr = 1'b0;
        chk("R5", flag, 1'b1);

        // R10: return to snapshot level keeps flag
        pin = pin ^ 8'h20;
        tick(4);
        chk("R10", flag, 1'b1);
        clr = 1'b1; tick(); clr = 1'b0;
        chk("R6", flag, 1'b0);

        // R3 and R6 via write strobe
        pin = pin ^ 8'h40;
        tick(4);
        chk("R4", flag, 1'b1);
        access_then_clear(1'b1, "R6");
        tick(4);
        chk("R3", flag, 1'b0);
        pin = pin ^ 8'h40;
        tick(4);
        chk("R3", flag, 1'b1);
        access_then_clear(1'b0, "R6");

        // R7: clear and new mismatch meet at the same edge
        pin = pin ^ 8'h10;
        tick(4);
        rd = 1'b1; tick(); rd = 1'b0;
        tick();
        chk("R10", flag, 1'b1);
        pin = pin ^ 8'h10;
        tick(2);
        clr = 1'b1; tick(); clr = 1'b0;
        chk("R7", flag, 1'b1);
        chk("R8", wake, 1'b1);
        access_then_clear(1'b0, "R6");

        // Random phase against the model
        for (int c = 0; c < 4000; c++) begin
            tick();
            chk("R4", flag, m_flag);
            chk("R8", wake, m_flag);
            if ($urandom_range(0, 7) == 0) pin = pin ^ 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 31) == 0) dir = 8'($urandom);
            rd  = ($urandom_range(0, 15) == 0);
            wr  = ($urandom_range(0, 23) == 0);
            clr = ($urandom_range(0, 5) == 0);
        end
        rd = 0; wr = 0; clr = 0;
        tick(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule